// File: doc/BRIEF.md
# Short-lived value register file

This block is a small associative store for results whose destination register has already been renamed again by the time they are produced. Holding such a value here lets it skip both the reorder-buffer write and the later copy into the architectural register file. Each held entry records the reorder-buffer slot of its producer, the architectural destination, the data and two branch tags. The first tag belongs to the branch ahead of the instruction that renamed the destination. The second tag belongs to the branch ahead of the producer itself. A pair of per-slot bit vectors, allocated and uncommitted-write, ties entries to reorder-buffer slots.

Results arrive on a valid/ready insert port. `ins_ready` may depend on the offered `ins_slot`. A result is taken only in a cycle where both `ins_valid` and `ins_ready` are high. A refused result is not held, and it is up to the producer to send it down the normal reorder-buffer path. The commit port reports a committing slot and its flush field. The mispredict port carries one branch tag. The exception pulse starts a drain of every held entry. The entries leaving because of a mispredicted renamer go out one at a time on a valid/ready evict stream. The entries leaving because of an exception go out on a valid/ready drain stream. On both output streams, an offered item stays in place while ready is low, and it is consumed in a cycle where valid and ready are both high.

Top module: `shortlived_rf`

## Requirements
- R1: After reset every entry is free. `ins_ready` is 1 for any slot. `ev_valid`, `dr_valid`, `busy` and `cmt_skip_arf` are 0.
- R2: `ins_ready` is 1 only when all of these hold: a free entry exists, the allocated bit of `ins_slot` is 0, `busy` is 0, `mp_valid` is 0 and `exc_valid` is 0. An accepted result goes into the lowest-index free entry, and it sets both the allocated bit and the uncommitted-write bit of its slot.
- R3: A result offered for a slot that already has a held entry is refused (`ins_ready` is 0).
- R4: When all entries are held, `ins_ready` is 0. A refused result leaves the allocated bit of its slot clear.
- R5: `cmt_skip_arf` equals `cmt_valid` AND the allocated bit of `cmt_slot`, in the same cycle.
- R6: A commit clears the uncommitted-write bit of `cmt_slot`. When `cmt_fs_valid` is set, the entry keyed by `cmt_fs_slot` is freed and its allocated bit cleared. This happens only if that slot's allocated bit is 1 and its uncommitted-write bit is 0. Otherwise the flush field has no effect.
- R7: A mispredict whose tag equals an entry's producer tag (tag 2) frees that entry and clears its allocated bit. Nothing is emitted for it on either stream.
- R8: A mispredict whose tag equals an entry's renamer tag (tag 1), but not its tag 2, queues that entry for eviction. The entry appears on the evict stream from the next cycle with its slot, destination and data. `ev_to_arf` is 1 when the slot's uncommitted-write bit is 0 (the value goes to the architectural file) and 0 when that bit is 1 (the value goes back to the reorder buffer).
- R9: Queued evictions leave lowest entry index first, one per handshake. Each departing entry is freed, and its allocated and uncommitted-write bits are cleared. `busy` is 1 while any eviction or drain is queued.
- R10: An `exc_valid` pulse queues every held entry, including any already queued for eviction, onto the drain stream. They leave lowest entry index first with destination and data. A mispredict in the same cycle is ignored, and the evict stream stays idle.
- R11: While `busy` is 1 no result is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Short-lived result offered |
| ins_ready | output | 1 | Result can be held this cycle |
| ins_slot | input | log2(SLOTS) | Reorder-buffer slot of the producer |
| ins_dest | input | AREG_W | Architectural destination |
| ins_bt1 | input | TAG_W | Tag of branch ahead of the renamer |
| ins_bt2 | input | TAG_W | Tag of branch ahead of the producer |
| ins_data | input | DATA_W | Result value |
| cmt_valid | input | 1 | A slot commits this cycle |
| cmt_slot | input | log2(SLOTS) | Committing slot |
| cmt_fs_valid | input | 1 | Committing instruction carries a flush field |
| cmt_fs_slot | input | log2(SLOTS) | Slot named by the flush field |
| cmt_skip_arf | output | 1 | Suppress the architectural-file copy for this commit |
| mp_valid | input | 1 | Branch mispredict |
| mp_tag | input | TAG_W | Tag of the mispredicted branch |
| exc_valid | input | 1 | Precise exception: drain all entries |
| ev_valid | output | 1 | Eviction value offered |
| ev_ready | input | 1 | Eviction consumer accepts |
| ev_to_arf | output | 1 | 1: to architectural file, 0: to reorder buffer |
| ev_slot | output | log2(SLOTS) | Slot of evicted value |
| ev_dest | output | AREG_W | Destination of evicted value |
| ev_data | output | DATA_W | Evicted value |
| dr_valid | output | 1 | Drain value offered |
| dr_ready | input | 1 | Drain consumer accepts |
| dr_dest | output | AREG_W | Destination of drained value |
| dr_data | output | DATA_W | Drained value |
| busy | output | 1 | Eviction or drain queue not empty |

## Verification
`ins_ready` and `cmt_skip_arf` are combinational views of the registered state, so they are due in the same cycle as the stimulus. A change of state caused by an insert, a commit or a mispredict shows at the outputs one cycle after the clock edge that takes it. The head of the evict or drain stream is due one cycle after the mispredict or the exception pulse. The next head is due one cycle after each handshake. The bench changes inputs on the falling edge and samples outputs 1 ns later, so every check reads the state produced by the rising edge just before.

// File: rtl/slrf_pkg.sv
`timescale 1ns/1ps
package slrf_pkg;
  // Life cycle of one storage entry.
  typedef enum logic [1:0] {
    ENT_FREE  = 2'd0,
    ENT_HELD  = 2'd1,
    ENT_EVICT = 2'd2,
    ENT_DRAIN = 2'd3
  } ent_state_t;
endpackage

// File: rtl/slrf_pick.sv
`timescale 1ns/1ps
// Lowest-index-first selector over a request vector.
module slrf_pick #(
  parameter int N  = 32,
  parameter int IW = 5
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/slrf_slot_track.sv
`timescale 1ns/1ps
// Per reorder-buffer slot bits: value held here, and not yet committed.
module slrf_slot_track #(
  parameter int SLOTS  = 64,
  parameter int SLOT_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [SLOT_W-1:0] set_slot,
  input  logic              cmt_en,
  input  logic [SLOT_W-1:0] cmt_slot,
  input  logic [SLOTS-1:0]  clr_vec,
  output logic [SLOTS-1:0]  alloc_o,
  output logic [SLOTS-1:0]  unc_o
);
  logic [SLOTS-1:0] alloc_q, unc_q, set_mask, cmt_mask;

  always_comb begin
    set_mask = '0;
    cmt_mask = '0;
    if (set_en) set_mask[set_slot] = 1'b1;
    if (cmt_en) cmt_mask[cmt_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alloc_q <= '0;
      unc_q   <= '0;
    end else begin
      alloc_q <= (alloc_q & ~clr_vec) | set_mask;
      unc_q   <= (unc_q & ~clr_vec & ~cmt_mask) | set_mask;
    end
  end

  assign alloc_o = alloc_q;
  assign unc_o   = unc_q;

  // R6
  unc_within_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unc_q & ~alloc_q) == '0);
endmodule

// File: rtl/slrf_entries.sv
`timescale 1ns/1ps
// Entry storage with per-entry removal and queueing decisions.
module slrf_entries
  import slrf_pkg::*;
#(
  parameter int ENTRIES = 32,
  parameter int IDX_W   = 5,
  parameter int SLOTS   = 64,
  parameter int SLOT_W  = 6,
  parameter int AREG_W  = 5,
  parameter int TAG_W   = 3,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_we,
  input  logic [IDX_W-1:0]  ins_idx,
  input  logic [SLOT_W-1:0] ins_slot,
  input  logic [AREG_W-1:0] ins_dest,
  input  logic [TAG_W-1:0]  ins_bt1,
  input  logic [TAG_W-1:0]  ins_bt2,
  input  logic [DATA_W-1:0] ins_data,
  input  logic              fs_do,
  input  logic [SLOT_W-1:0] fs_slot,
  input  logic              mp_do,
  input  logic [TAG_W-1:0]  mp_tag,
  input  logic              exc_do,
  input  logic              ev_pop,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic              dr_pop,
  input  logic [IDX_W-1:0]  dr_idx,
  output logic [ENTRIES-1:0] held_o,
  output logic [ENTRIES-1:0] ev_req_o,
  output logic [ENTRIES-1:0] dr_req_o,
  output logic [SLOT_W-1:0]  slot_o [ENTRIES],
  output logic [AREG_W-1:0]  dest_o [ENTRIES],
  output logic [DATA_W-1:0]  data_o [ENTRIES],
  output logic [SLOTS-1:0]   clr_vec_o
);
  logic [ENTRIES-1:0] kill_v;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    ent_state_t        st_q;
    logic [SLOT_W-1:0] slot_q;
    logic [AREG_W-1:0] dest_q;
    logic [TAG_W-1:0]  bt1_q, bt2_q;
    logic [DATA_W-1:0] data_q;
    logic held, hit_ins, kill;

    assign held    = (st_q != ENT_FREE);
    assign hit_ins = ins_we && (ins_idx == IDX_W'(g));
    assign kill    = held && ((fs_do && (slot_q == fs_slot)) ||
                              (mp_do && (st_q != ENT_DRAIN) && (bt2_q == mp_tag)) ||
                              (ev_pop && (ev_idx == IDX_W'(g))) ||
                              (dr_pop && (dr_idx == IDX_W'(g))));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        st_q   <= ENT_FREE;
        slot_q <= '0;
        dest_q <= '0;
        bt1_q  <= '0;
        bt2_q  <= '0;
        data_q <= '0;
      end else if (hit_ins) begin
        st_q   <= ENT_HELD;
        slot_q <= ins_slot;
        dest_q <= ins_dest;
        bt1_q  <= ins_bt1;
        bt2_q  <= ins_bt2;
        data_q <= ins_data;
      end else if (kill) begin
        st_q <= ENT_FREE;
      end else if (held && exc_do) begin
        st_q <= ENT_DRAIN;
      end else if ((st_q == ENT_HELD) && mp_do && (bt1_q == mp_tag)) begin
        st_q <= ENT_EVICT;
      end
    end

    assign held_o[g]   = held;
    assign ev_req_o[g] = (st_q == ENT_EVICT);
    assign dr_req_o[g] = (st_q == ENT_DRAIN);
    assign kill_v[g]   = kill;
    assign slot_o[g]   = slot_q;
    assign dest_o[g]   = dest_q;
    assign data_o[g]   = data_q;

    // R7
    bt2_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mp_do && ((st_q == ENT_HELD) || (st_q == ENT_EVICT)) && (bt2_q == mp_tag))
        |=> (st_q == ENT_FREE));
  end

  always_comb begin
    clr_vec_o = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (kill_v[e]) clr_vec_o[slot_o[e]] = 1'b1;
    end
  end
endmodule

// File: rtl/shortlived_rf.sv
`timescale 1ns/1ps
module shortlived_rf #(
  parameter int ENTRIES = 32,
  parameter int SLOTS   = 64,
  parameter int AREG_W  = 5,
  parameter int TAG_W   = 3,
  parameter int DATA_W  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ins_valid,
  output logic                     ins_ready,
  input  logic [$clog2(SLOTS)-1:0] ins_slot,
  input  logic [AREG_W-1:0]        ins_dest,
  input  logic [TAG_W-1:0]         ins_bt1,
  input  logic [TAG_W-1:0]         ins_bt2,
  input  logic [DATA_W-1:0]        ins_data,
  input  logic                     cmt_valid,
  input  logic [$clog2(SLOTS)-1:0] cmt_slot,
  input  logic                     cmt_fs_valid,
  input  logic [$clog2(SLOTS)-1:0] cmt_fs_slot,
  output logic                     cmt_skip_arf,
  input  logic                     mp_valid,
  input  logic [TAG_W-1:0]         mp_tag,
  input  logic                     exc_valid,
  output logic                     ev_valid,
  input  logic                     ev_ready,
  output logic                     ev_to_arf,
  output logic [$clog2(SLOTS)-1:0] ev_slot,
  output logic [AREG_W-1:0]        ev_dest,
  output logic [DATA_W-1:0]        ev_data,
  output logic                     dr_valid,
  input  logic                     dr_ready,
  output logic [AREG_W-1:0]        dr_dest,
  output logic [DATA_W-1:0]        dr_data,
  output logic                     busy
);
  localparam int IDX_W  = $clog2(ENTRIES);
  localparam int SLOT_W = $clog2(SLOTS);

  logic [SLOTS-1:0]   alloc, unc, clr_vec, held_map;
  logic [ENTRIES-1:0] held, ev_req, dr_req;
  logic [SLOT_W-1:0]  slot_arr [ENTRIES];
  logic [AREG_W-1:0]  dest_arr [ENTRIES];
  logic [DATA_W-1:0]  data_arr [ENTRIES];
  logic               free_any, ev_any, dr_any;
  logic [IDX_W-1:0]   free_idx, ev_idx, dr_idx;
  logic               ins_we, fs_do, mp_do, ev_pop, dr_pop;

  slrf_pick #(.N(ENTRIES), .IW(IDX_W)) i_free_pick (
    .req(~held), .any(free_any), .idx(free_idx));
  slrf_pick #(.N(ENTRIES), .IW(IDX_W)) i_ev_pick (
    .req(ev_req), .any(ev_any), .idx(ev_idx));
  slrf_pick #(.N(ENTRIES), .IW(IDX_W)) i_dr_pick (
    .req(dr_req), .any(dr_any), .idx(dr_idx));

  assign busy      = ev_any || dr_any;
  assign ins_ready = free_any && !alloc[ins_slot] && !busy && !mp_valid && !exc_valid;
  assign ins_we    = ins_valid && ins_ready;
  assign fs_do     = cmt_valid && cmt_fs_valid && alloc[cmt_fs_slot] && !unc[cmt_fs_slot];
  assign mp_do     = mp_valid && !exc_valid;
  assign cmt_skip_arf = cmt_valid && alloc[cmt_slot];

  assign ev_valid  = ev_any;
  assign ev_slot   = slot_arr[ev_idx];
  assign ev_dest   = dest_arr[ev_idx];
  assign ev_data   = data_arr[ev_idx];
  assign ev_to_arf = !unc[ev_slot];
  assign ev_pop    = ev_valid && ev_ready;

  assign dr_valid  = dr_any;
  assign dr_dest   = dest_arr[dr_idx];
  assign dr_data   = data_arr[dr_idx];
  assign dr_pop    = dr_valid && dr_ready;

  slrf_entries #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .SLOTS(SLOTS), .SLOT_W(SLOT_W),
    .AREG_W(AREG_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) i_entries (
    .clk(clk), .rst_n(rst_n),
    .ins_we(ins_we), .ins_idx(free_idx), .ins_slot(ins_slot), .ins_dest(ins_dest),
    .ins_bt1(ins_bt1), .ins_bt2(ins_bt2), .ins_data(ins_data),
    .fs_do(fs_do), .fs_slot(cmt_fs_slot),
    .mp_do(mp_do), .mp_tag(mp_tag), .exc_do(exc_valid),
    .ev_pop(ev_pop), .ev_idx(ev_idx), .dr_pop(dr_pop), .dr_idx(dr_idx),
    .held_o(held), .ev_req_o(ev_req), .dr_req_o(dr_req),
    .slot_o(slot_arr), .dest_o(dest_arr), .data_o(data_arr),
    .clr_vec_o(clr_vec)
  );

  slrf_slot_track #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) i_slot_track (
    .clk(clk), .rst_n(rst_n),
    .set_en(ins_we), .set_slot(ins_slot),
    .cmt_en(cmt_valid), .cmt_slot(cmt_slot),
    .clr_vec(clr_vec), .alloc_o(alloc), .unc_o(unc)
  );

  always_comb begin
    held_map = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      if (held[e]) held_map[slot_arr[e]] = 1'b1;
    end
  end

  // R2
  alloc_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc == held_map);

  // R2
  insert_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ins_we |=> alloc[$past(ins_slot)]);

  // R10
  ev_dr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && dr_valid));

  // R9
  evict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ev_ready && !exc_valid && !mp_valid && !cmt_valid)
      |=> (ev_valid && $stable(ev_slot)));
endmodule

// File: tb/test_shortlived_rf.sv
`timescale 1ns/1ps
module test_shortlived_rf;
  localparam int ENTRIES = 32;
  localparam int SLOTS   = 64;
  localparam int AREG_W  = 5;
  localparam int TAG_W   = 3;
  localparam int DATA_W  = 32;
  localparam int SW      = $clog2(SLOTS);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, ins_valid, ins_ready, cmt_valid, cmt_fs_valid, cmt_skip_arf;
  logic mp_valid, exc_valid, ev_valid, ev_ready, ev_to_arf, dr_valid, dr_ready, busy;
  logic [SW-1:0] ins_slot, cmt_slot, cmt_fs_slot, ev_slot;
  logic [AREG_W-1:0] ins_dest, ev_dest, dr_dest;
  logic [TAG_W-1:0] ins_bt1, ins_bt2, mp_tag;
  logic [DATA_W-1:0] ins_data, ev_data, dr_data;

  shortlived_rf #(.ENTRIES(ENTRIES), .SLOTS(SLOTS), .AREG_W(AREG_W),
                  .TAG_W(TAG_W), .DATA_W(DATA_W)) i_shortlived_rf (
    .clk(clk), .rst_n(rst_n),
    .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_slot(ins_slot),
    .ins_dest(ins_dest), .ins_bt1(ins_bt1), .ins_bt2(ins_bt2), .ins_data(ins_data),
    .cmt_valid(cmt_valid), .cmt_slot(cmt_slot), .cmt_fs_valid(cmt_fs_valid),
    .cmt_fs_slot(cmt_fs_slot), .cmt_skip_arf(cmt_skip_arf),
    .mp_valid(mp_valid), .mp_tag(mp_tag), .exc_valid(exc_valid),
    .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_to_arf(ev_to_arf),
    .ev_slot(ev_slot), .ev_dest(ev_dest), .ev_data(ev_data),
    .dr_valid(dr_valid), .dr_ready(dr_ready), .dr_dest(dr_dest), .dr_data(dr_data),
    .busy(busy)
  );

  int total = 0;
  int bad = 0;

  task automatic chk_eq(input string req, input string what,
                        input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Each task starts just after a falling edge and returns one cycle later.
  task automatic ins(input int s, input int d, input int b1, input int b2,
                     input longint dat, input bit exp, input string req);
    ins_slot = SW'(s); ins_dest = AREG_W'(d); ins_bt1 = TAG_W'(b1);
    ins_bt2 = TAG_W'(b2); ins_data = DATA_W'(dat); ins_valid = 1'b1;
    #1 chk_eq(req, "ins_ready", ins_ready, exp);
    @(negedge clk) ins_valid = 1'b0;
  endtask

  task automatic cmt(input int s, input bit fsv, input int fs, input bit exp,
                     input string req);
    cmt_slot = SW'(s); cmt_fs_valid = fsv; cmt_fs_slot = SW'(fs); cmt_valid = 1'b1;
    #1 chk_eq(req, "cmt_skip_arf", cmt_skip_arf, exp);
    @(negedge clk) begin cmt_valid = 1'b0; cmt_fs_valid = 1'b0; end
  endtask

  task automatic expect_ev(input int s, input int d, input longint dat,
                           input bit arf, input string req);
    #1;
    chk_eq(req, "ev_valid", ev_valid, 1);
    chk_eq(req, "ev_slot", ev_slot, s);
    chk_eq(req, "ev_dest", ev_dest, d);
    chk_eq(req, "ev_data", ev_data, dat);
    chk_eq(req, "ev_to_arf", ev_to_arf, arf);
    ev_ready = 1'b1;
    @(negedge clk) ev_ready = 1'b0;
  endtask

  task automatic expect_dr(input int d, input longint dat, input string req);
    #1;
    chk_eq(req, "dr_valid", dr_valid, 1);
    chk_eq(req, "dr_dest", dr_dest, d);
    chk_eq(req, "dr_data", dr_data, dat);
    chk_eq(req, "ev_valid", ev_valid, 0);
    dr_ready = 1'b1;
    @(negedge clk) dr_ready = 1'b0;
  endtask

  // Insert table: slot, dest, tag1, tag2, data, expected ready.
  localparam int     NV = 5;
  localparam int     V_SLOT [NV] = '{3, 5, 3, 7, 9};
  localparam int     V_DEST [NV] = '{1, 2, 6, 3, 4};
  localparam int     V_BT1  [NV] = '{1, 2, 2, 2, 2};
  localparam int     V_BT2  [NV] = '{0, 1, 3, 2, 0};
  localparam longint V_DATA [NV] = '{'hA0, 'hA1, 'hEE, 'hA3, 'hA4};
  localparam bit     V_RDY  [NV] = '{1, 1, 0, 1, 1};

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; cmt_valid = 1'b0; cmt_fs_valid = 1'b0;
    mp_valid = 1'b0; exc_valid = 1'b0; ev_ready = 1'b0; dr_ready = 1'b0;
    ins_slot = '0; ins_dest = '0; ins_bt1 = '0; ins_bt2 = '0; ins_data = '0;
    cmt_slot = '0; cmt_fs_slot = '0; mp_tag = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk_eq("R1", "ins_ready", ins_ready, 1);
    chk_eq("R1", "ev_valid", ev_valid, 0);
    chk_eq("R1", "dr_valid", dr_valid, 0);
    chk_eq("R1", "busy", busy, 0);
    chk_eq("R1", "cmt_skip_arf", cmt_skip_arf, 0);
    @(negedge clk);

    // R2 and R3: table of inserts, row 2 repeats slot 3
    for (int v = 0; v < NV; v++) begin
      ins(V_SLOT[v], V_DEST[v], V_BT1[v], V_BT2[v], V_DATA[v], V_RDY[v],
          V_RDY[v] ? "R2" : "R3");
    end

    // R5: skip only for held slots
    cmt(3, 0, 0, 1, "R5");
    cmt(4, 0, 0, 0, "R5");
    // R6: flush of slot 9 while still uncommitted has no effect
    cmt(20, 1, 9, 0, "R6");
    cmt(9, 0, 0, 1, "R6");
    // R6: flush of committed slot 3 frees it
    cmt(21, 1, 3, 0, "R6");
    cmt(3, 0, 0, 0, "R6");

    // R7 / R8: tag 2 drops slot 7, evicts slots 5 and 9
    mp_tag = TAG_W'(2); mp_valid = 1'b1;
    @(negedge clk) mp_valid = 1'b0;
    #1 chk_eq("R9", "busy", busy, 1);
    ins(30, 0, 0, 0, 'h55, 0, "R11");
    expect_ev(5, 2, 'hA1, 0, "R8");
    expect_ev(9, 4, 'hA4, 1, "R9");
    #1;
    chk_eq("R9", "ev_valid", ev_valid, 0);
    chk_eq("R9", "busy", busy, 0);
    cmt(7, 0, 0, 0, "R7");
    cmt(5, 0, 0, 0, "R9");

    // R4: fill every entry, then one more is refused
    for (int i = 0; i < ENTRIES; i++) begin
      ins(i, i, 5, 1, 'h100 + i, 1, "R2");
    end
    ins(40, 7, 0, 0, 'h77, 0, "R4");
    cmt(40, 0, 0, 0, "R4");

    // R10: exception with a matching mispredict in the same cycle
    mp_tag = TAG_W'(5); mp_valid = 1'b1; exc_valid = 1'b1;
    @(negedge clk) begin mp_valid = 1'b0; exc_valid = 1'b0; end
    for (int i = 0; i < ENTRIES; i++) begin
      expect_dr(i, 'h100 + i, "R10");
    end
    #1;
    chk_eq("R10", "dr_valid", dr_valid, 0);
    chk_eq("R10", "busy", busy, 0);
    ins_slot = '0;
    #1 chk_eq("R10", "ins_ready", ins_ready, 1);
    @(negedge clk);
    cmt(0, 0, 0, 0, "R10");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule